// File: doc/BRIEF.md
# Multi-Channel Hit Trigger and Sample-Hold Strobe Sequencer

This block takes the discriminator hits of a bank of front-end channels and forms a chip-level trigger from them. That trigger goes to a trigger line shared with neighbouring chips. The block also produces the one sample-and-hold strobe that freezes the charge and timing values of every channel. Each enabled channel gets a one-cycle start pulse when its hit first rises. That pulse opens the channel's own time measurement, and the common strobe later closes it. A channel that fires after the first one therefore records a shorter interval.

The strobe has three selectable sources. The first is an external strobe pin, passed straight through. The second is this chip's own trigger, delayed by a programmable number of clock cycles. The third is a trigger raised by any other chip on two shared trigger input lines, delayed by the same amount. After the strobe, the sequencer ignores new activity until the readout logic reports completion. Settings arrive after power-up over a three-wire serial shift interface. They are copied into the working registers only while the sequencer is idle.

Top module: `hit_strobe_sequencer`

## Requirements
- R1: `trig_o` is high in the same cycle that at least one channel whose enable bit is set has its hit input high, and is low otherwise; it is forced low while the sequencer holds after a strobe.
- R2: With mode code 0 (external), `strobe_o` equals `ext_sh_i` in the same cycle, and a rising `ext_sh_i` while idle moves the sequencer into the hold state.
- R3: With mode code 1 (internal), `strobe_o` is high for exactly one cycle, in the cycle that follows the D-th clock edge after the first edge at which `trig_o` is high while idle (D = delay field). D = 0 therefore gives the strobe in the cycle right after the trigger edge.
- R4: With mode code 2 (shared lines), the delay starts at the first edge at which `line_a_i` or `line_b_i` is high while idle, with the same timing as R3; local hits alone never start it.
- R5: In mode codes 1 and 2, `ext_sh_i` has no effect on `strobe_o`.
- R6: `start_o[i]` is high for one cycle, in the cycle where the enabled hit `hit_i[i]` goes from low to high; a channel rising while others are already running still gets its own pulse.
- R7: A channel with its enable bit clear never pulses `start_o` and never raises `trig_o`; a channel that has pulsed does not pulse again until the sequencer returns to idle.
- R8: From the strobe until a cycle in which `readout_done_i` is high, the sequencer gives no `start_o` pulse and no `trig_o`, and no new strobe is generated; `readout_done_i` returns it to idle.
- R9: Configuration bits are shifted in on rising `cfg_sclk`, first bit sent ending up as MSB, in the layout {mode[1:0], delay[DLY_W-1:0], enable[NCH-1:0]}. A rising `cfg_load` copies them into a shadow register, and the shadow reaches the working settings only while idle.
- R10: `status_o` = {valid, from_lines, mode[1:0]}. It is set at the strobe to the mode that fired, with from_lines = 1 only for mode 2. It clears when `readout_done_i` returns the sequencer to idle.
- R11: After reset the working settings are mode 1, delay 0, all channels disabled, and `strobe_o`, `trig_o`, `start_o` and `status_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NCH | Per-channel discriminator hits |
| cfg_sclk | input | 1 | Serial configuration shift clock (sampled) |
| cfg_sdata | input | 1 | Serial configuration data |
| cfg_load | input | 1 | Copy shifted bits to the shadow register on its rise |
| ext_sh_i | input | 1 | External sample-hold strobe pin |
| line_a_i | input | 1 | Shared trigger line A from other chips |
| line_b_i | input | 1 | Shared trigger line B from other chips |
| readout_done_i | input | 1 | Readout finished, return to idle |
| trig_o | output | 1 | Chip trigger to the shared off-chip line |
| strobe_o | output | 1 | Common sample-and-hold strobe |
| start_o | output | NCH | Per-channel time-measurement start pulses |
| status_o | output | 4 | {valid, from_lines, mode[1:0]} of the last strobe |

## Verification
Two functions can land on the same cycle: a channel's start pulse and the strobe that closes every measurement. So can a configuration update and an active capture. The bench raises a late channel while the delay counter is still running and requires its start pulse. It then raises another channel in the cycle just after the strobe and requires that no start and no trigger appear. A new configuration is loaded while the sequencer holds. The bench shows that the old mode still governs the strobe pin until readout completes, and that the new mode takes over afterwards.

// File: rtl/hss_pkg.sv
package hss_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_HOLD = 2'd2
   } seq_state_t;

   localparam logic [1:0] MODE_EXT  = 2'd0;
   localparam logic [1:0] MODE_INT  = 2'd1;
   localparam logic [1:0] MODE_LINE = 2'd2;

   localparam int STATUS_W = 4;
endpackage

// File: rtl/hss_cfg_shift.sv
module hss_cfg_shift #(
   parameter int NCH   = 64,
   parameter int DLY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sclk,
   input  logic             sdata,
   input  logic             load,
   input  logic             apply,
   output logic [1:0]       mode_o,
   output logic [DLY_W-1:0] delay_o,
   output logic [NCH-1:0]   en_o
);
   localparam int CFG_W = 2 + DLY_W + NCH;

   logic             sclk_q, load_q;
   logic [CFG_W-1:0] shift_q, shadow_q, active_q;
   logic             sclk_rise, load_rise;

   assign sclk_rise = sclk & ~sclk_q;
   assign load_rise = load & ~load_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_q   <= 1'b0;
         load_q   <= 1'b0;
         shift_q  <= '0;
         shadow_q <= {hss_pkg::MODE_INT, {DLY_W{1'b0}}, {NCH{1'b0}}};
         active_q <= {hss_pkg::MODE_INT, {DLY_W{1'b0}}, {NCH{1'b0}}};
      end else begin
         sclk_q <= sclk;
         load_q <= load;
         if (sclk_rise) shift_q <= {shift_q[CFG_W-2:0], sdata};
         if (load_rise) shadow_q <= shift_q;
         if (apply)     active_q <= shadow_q;
      end
   end

   assign mode_o  = active_q[CFG_W-1 -: 2];
   assign delay_o = active_q[NCH +: DLY_W];
   assign en_o    = active_q[NCH-1:0];
endmodule

// File: rtl/hss_chan_front.sv
module hss_chan_front #(
   parameter int NCH = 64
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] hit_i,
   input  logic [NCH-1:0] en_i,
   input  logic           block_i,
   input  logic           clear_i,
   output logic [NCH-1:0] start_o,
   output logic           any_o
);
   logic [NCH-1:0] armed_hits;

   assign armed_hits = hit_i & en_i;
   assign any_o      = |armed_hits;

   for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
      logic hit_q, started_q;

      assign start_o[ch] = armed_hits[ch] & ~hit_q & ~started_q & ~block_i;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hit_q     <= 1'b0;
            started_q <= 1'b0;
         end else begin
            hit_q <= hit_i[ch];
            if (clear_i)          started_q <= 1'b0;
            else if (start_o[ch]) started_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/hss_strobe_fsm.sv
module hss_strobe_fsm #(
   parameter int DLY_W = 10
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [1:0]                    mode_i,
   input  logic [DLY_W-1:0]              delay_i,
   input  logic                          local_trig_i,
   input  logic                          line_trig_i,
   input  logic                          ext_sh_i,
   input  logic                          done_i,
   output logic                          strobe_o,
   output logic                          idle_o,
   output logic                          hold_o,
   output logic [hss_pkg::STATUS_W-1:0]  status_o
);
   import hss_pkg::*;

   seq_state_t       state_q;
   logic [DLY_W-1:0] cnt_q;
   logic [1:0]       fired_mode_q;
   logic             strobe_q, ext_q;
   logic             go;
   logic [STATUS_W-1:0] status_q;

   always_comb begin
      unique case (mode_i)
         MODE_EXT:  go = ext_sh_i & ~ext_q;
         MODE_LINE: go = line_trig_i;
         default:   go = local_trig_i;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         cnt_q        <= '0;
         fired_mode_q <= MODE_INT;
         strobe_q     <= 1'b0;
         ext_q        <= 1'b0;
         status_q     <= '0;
      end else begin
         ext_q    <= ext_sh_i;
         strobe_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (go) begin
                  fired_mode_q <= mode_i;
                  if (mode_i == MODE_EXT) begin
                     state_q  <= ST_HOLD;
                     status_q <= {1'b1, 1'b0, MODE_EXT};
                  end else if (delay_i == '0) begin
                     strobe_q <= 1'b1;
                     state_q  <= ST_HOLD;
                     status_q <= {1'b1, mode_i == MODE_LINE, mode_i};
                  end else begin
                     cnt_q   <= delay_i - 1'b1;
                     state_q <= ST_WAIT;
                  end
               end
            end
            ST_WAIT: begin
               if (cnt_q == '0) begin
                  strobe_q <= 1'b1;
                  state_q  <= ST_HOLD;
                  status_q <= {1'b1, fired_mode_q == MODE_LINE, fired_mode_q};
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            ST_HOLD: begin
               if (done_i) begin
                  state_q  <= ST_IDLE;
                  status_q <= '0;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign strobe_o = (mode_i == MODE_EXT) ? ext_sh_i : strobe_q;
   assign idle_o   = (state_q == ST_IDLE);
   assign hold_o   = (state_q == ST_HOLD);
   assign status_o = status_q;
endmodule

// File: rtl/hit_strobe_sequencer.sv
module hit_strobe_sequencer #(
   parameter int NCH   = 64,
   parameter int DLY_W = 10
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NCH-1:0]               hit_i,
   input  logic                         cfg_sclk,
   input  logic                         cfg_sdata,
   input  logic                         cfg_load,
   input  logic                         ext_sh_i,
   input  logic                         line_a_i,
   input  logic                         line_b_i,
   input  logic                         readout_done_i,
   output logic                         trig_o,
   output logic                         strobe_o,
   output logic [NCH-1:0]               start_o,
   output logic [hss_pkg::STATUS_W-1:0] status_o
);
   if (NCH < 1) begin : g_bad_nch
      $error("hit_strobe_sequencer: NCH must be at least 1");
   end
   if (DLY_W < 1 || DLY_W > 16) begin : g_bad_dly
      $error("hit_strobe_sequencer: DLY_W must lie in 1..16");
   end

   logic [1:0]       act_mode;
   logic [DLY_W-1:0] act_delay;
   logic [NCH-1:0]   act_en;
   logic             idle, hold, any_hit;

   hss_cfg_shift #(.NCH(NCH), .DLY_W(DLY_W)) u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .sclk    (cfg_sclk),
      .sdata   (cfg_sdata),
      .load    (cfg_load),
      .apply   (idle),
      .mode_o  (act_mode),
      .delay_o (act_delay),
      .en_o    (act_en)
   );

   hss_chan_front #(.NCH(NCH)) u_front (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_i),
      .en_i    (act_en),
      .block_i (hold),
      .clear_i (hold & readout_done_i),
      .start_o (start_o),
      .any_o   (any_hit)
   );

   assign trig_o = any_hit & ~hold;

   hss_strobe_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode_i       (act_mode),
      .delay_i      (act_delay),
      .local_trig_i (trig_o),
      .line_trig_i  (line_a_i | line_b_i),
      .ext_sh_i     (ext_sh_i),
      .done_i       (readout_done_i),
      .strobe_o     (strobe_o),
      .idle_o       (idle),
      .hold_o       (hold),
      .status_o     (status_o)
   );
endmodule

// File: rtl/hss_checker.sv
module hss_checker #(
   parameter int NCH   = 64,
   parameter int DLY_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NCH-1:0]   hit_i,
   input logic             trig_o,
   input logic             strobe_o,
   input logic [NCH-1:0]   start_o,
   input logic [3:0]       status_o,
   input logic [1:0]       act_mode,
   input logic [DLY_W-1:0] act_delay,
   input logic [NCH-1:0]   act_en,
   input logic             idle,
   input logic             hold
);
   AST_TRIG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      trig_o |-> ((hit_i & act_en) != '0)); // R1

   AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode != 2'd0 && strobe_o) |=> !strobe_o); // R3

   AST_STROBE_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode != 2'd0 && strobe_o) |-> hold); // R5

   AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (!trig_o && start_o == '0)); // R8

   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> ($stable(act_mode) && $stable(act_delay) && $stable(act_en))); // R9

   AST_STATUS_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (act_mode != 2'd0 && strobe_o) |-> status_o[3]); // R10
endmodule

bind hit_strobe_sequencer hss_checker #(.NCH(NCH), .DLY_W(DLY_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .hit_i     (hit_i),
   .trig_o    (trig_o),
   .strobe_o  (strobe_o),
   .start_o   (start_o),
   .status_o  (status_o),
   .act_mode  (act_mode),
   .act_delay (act_delay),
   .act_en    (act_en),
   .idle      (idle),
   .hold      (hold)
);

// File: tb/hit_strobe_sequencer_bench.sv
module hit_strobe_sequencer_bench;
   localparam int NCH   = 64;
   localparam int DLY_W = 10;
   localparam int CFG_W = 2 + DLY_W + NCH;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NCH-1:0]   hit = '0;
   logic             sclk = 1'b0, sdata = 1'b0, load = 1'b0;
   logic             ext_sh = 1'b0, line_a = 1'b0, line_b = 1'b0, done = 1'b0;
   logic             trig, strobe;
   logic [NCH-1:0]   start;
   logic [3:0]       status;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   hit_strobe_sequencer #(.NCH(NCH), .DLY_W(DLY_W)) u_hit_strobe_sequencer (
      .clk(clk), .rst_n(rst_n), .hit_i(hit),
      .cfg_sclk(sclk), .cfg_sdata(sdata), .cfg_load(load),
      .ext_sh_i(ext_sh), .line_a_i(line_a), .line_b_i(line_b),
      .readout_done_i(done), .trig_o(trig), .strobe_o(strobe),
      .start_o(start), .status_o(status)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic settle();
      #1;
   endtask

   task automatic load_cfg(input logic [1:0] mode, input logic [DLY_W-1:0] dly,
                           input logic [NCH-1:0] en);
      logic [CFG_W-1:0] word;
      word = {mode, dly, en};
      for (int b = CFG_W - 1; b >= 0; b--) begin
         sdata = word[b];
         sclk  = 1'b1; step();
         sclk  = 1'b0; step();
      end
      load = 1'b1; step();
      load = 1'b0; step(); step();
   endtask

   task automatic finish_readout();
      done = 1'b1; step();
      done = 1'b0; step();
   endtask

   task automatic t_reset();
      settle();
      check("R11 strobe", strobe, 0);
      check("R11 trig", trig, 0);
      check("R11 start", start, 0);
      check("R11 status", status, 0);
      hit = {NCH{1'b1}}; settle();
      check("R11 trig disabled at reset", trig, 0);
      check("R7 start disabled", start, 0);
      hit = '0; step();
   endtask

   task automatic t_internal_delay();
      logic [NCH-1:0] en;
      en = {NCH{1'b1}}; en[5] = 1'b0;
      load_cfg(2'd1, 10'd3, en);
      hit[5] = 1'b1; settle();
      check("R7 disabled channel no trig", trig, 0);
      check("R7 disabled channel no start", start, 0);
      step();
      check("R7 no strobe from disabled", strobe, 0);
      hit[2] = 1'b1; settle();
      check("R1 trig from enabled hit", trig, 1);
      check("R6 start ch2", start, 64'd1 << 2);
      for (int s = 1; s <= 5; s++) begin
         step();
         check("R3 strobe timing D=3", strobe, (s == 4));
         if (s == 1) begin
            hit[2] = 1'b0; settle();
         end
         if (s == 2) begin
            hit[7] = 1'b1; hit[2] = 1'b1; settle();
            check("R6 late channel start / R7 no restart", start, 64'd1 << 7);
         end
         if (s == 4) begin
            check("R10 status internal", status, 4'b1001);
            hit[9] = 1'b1; settle();
            check("R8 no start in hold", start, 0);
            check("R8 no trig in hold", trig, 0);
         end
      end
      hit = '0; step();
      finish_readout();
      check("R10 status cleared", status, 0);
   endtask

   task automatic t_delay_zero();
      load_cfg(2'd1, 10'd0, {NCH{1'b1}});
      hit[40] = 1'b1; settle();
      check("R3 strobe low before edge", strobe, 0);
      step();
      check("R3 strobe D=0 next cycle", strobe, 1);
      step();
      check("R3 strobe one cycle", strobe, 0);
      hit = '0;
      finish_readout();
   endtask

   task automatic t_shared_lines();
      load_cfg(2'd2, 10'd2, {NCH{1'b1}});
      hit[0] = 1'b1; settle();
      check("R6 start in line mode", start, 64'd1);
      check("R1 trig in line mode", trig, 1);
      for (int s = 1; s <= 6; s++) begin
         if (s == 3) ext_sh = 1'b1;
         if (s == 4) ext_sh = 1'b0;
         settle();
         check("R4/R5 no strobe from local hit or pin", strobe, 0);
         step();
      end
      hit = '0;
      line_b = 1'b1;
      for (int s = 1; s <= 4; s++) begin
         step();
         if (s == 1) line_b = 1'b0;
         check("R4 strobe timing via line B", strobe, (s == 3));
         if (s == 3) check("R10 status lines", status, 4'b1110);
      end
      finish_readout();
   endtask

   task automatic t_external();
      load_cfg(2'd0, 10'd5, '0);
      ext_sh = 1'b1; settle();
      check("R2 strobe follows pin high", strobe, 1);
      step();
      check("R10 status external", status, 4'b1000);
      ext_sh = 1'b0; settle();
      check("R2 strobe follows pin low", strobe, 0);
      step();
      finish_readout();
   endtask

   task automatic t_cfg_only_idle();
      logic [NCH-1:0] en;
      en = '0; en[3] = 1'b1;
      load_cfg(2'd1, 10'd0, en);
      hit[3] = 1'b1; step();
      check("R3 strobe before reconfig", strobe, 1);
      load_cfg(2'd0, 10'd0, '0);
      ext_sh = 1'b1; settle();
      check("R9 new mode not applied in hold", strobe, 0);
      ext_sh = 1'b0; hit = '0; step();
      finish_readout(); step();
      ext_sh = 1'b1; settle();
      check("R9 new mode applied after idle", strobe, 1);
      ext_sh = 1'b0; step();
      finish_readout();
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected<150000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      t_reset();
      t_internal_delay();
      t_delay_zero();
      t_shared_lines();
      t_external();
      t_cfg_only_idle();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule